// File: doc/BRIEF.md
# Serial Gigabit Link Auto-Negotiation Controller

This block negotiates an Ethernet gigabit link on top of an 8b/10b PCS byte stream. Each clock it takes one received byte and its control-character flag, and keeps the last four in a short history. From that history it picks out configuration ordered sets and IDLE2 ordered sets. Configuration sets give the link partner's advertised link state, duplex and speed, and they drive a negotiation sequencer. Complete IDLE2 pairs tell the block that the PHY side is running normally.

The sequencer moves from reset through restart, ability matching and acknowledge matching to a link-OK state. It is paced by one of two external link-timer pulses, picked by the PHY kind. It also supplies the 16-bit configuration word that a separate ordered-set transmitter sends. Software-style controls let the user force a speed, turn negotiation off, or hold the PHY in reset.

Top module: `sgl_autoneg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs take these values: `an_phase` 0, `phy_up` 0, `partner_link` 0, `partner_fdx` 0, raw speed 2'b11 (`speed_out` reads 2'b11 with `speed_force` 0), and `tx_cfg_word` 16'h0021.
- R2: A primary configuration set is four bytes in a row. The first is control byte 0xBC. The second is data byte 0xB5. The third is a data low byte and the fourth a data high byte. One clock after the fourth byte is captured, the outputs load from the high byte: bit 7 goes to `partner_link`, bit 4 to `partner_fdx`, and bits 3:2 to the speed code.
- R3: A secondary configuration set has data byte 0x42 in place of 0xB5. It leaves `partner_link`, `partner_fdx` and the speed unchanged.
- R4: A decoded primary configuration set clears `phy_up`. An IDLE2 pair, control 0xBC followed by data 0x50, sets `phy_up`.
- R5: While `neg_off` is high, `phy_up` is forced to 1, `an_phase` is held at 0, and configuration sets do not change the partner fields.
- R6: While `phy_rst_n` is low, `partner_link`, `partner_fdx` and `phy_up` are cleared, the speed is set to 2'b11 and `an_phase` is 0. This takes priority over `neg_off`.
- R7: A nonzero `speed_force` is driven on `speed_out` in place of the decoded speed. A zero `speed_force` passes the decoded speed.
- R8: `tx_cfg_word` always has low byte 0x21. Its high byte is 0x00 in phases 0 to 3 and 0x40 in phases 4 to 7.
- R9: `an_phase` codes are: 0 off, 1 enable, 2 restart, 3 ability match, 4 acknowledge match, 5 acknowledge complete, 6 idle wait, 7 link OK. After reset the block goes 0, 1, 2 on consecutive clocks. It leaves 2 for 3 on the first selected timer pulse.
- R10: Phase 3 moves to 4 after three configuration words in a row (either form) that are equal. A word that differs from the previous one starts the count again at one.
- R11: Phase 4 moves to 5 after three configuration words with bit 14 (high byte bit 6) set. A word with that bit clear resets the count to zero.
- R12: Phases 5 and 6 each advance on the second selected timer pulse after the phase is entered.
- R13: A configuration set received in phase 7 returns the block to phase 3.
- R14: When `phy_kind` is 1, the selected timer is `tick_long`. For every other kind it is `tick_short`. The pulse that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_rst_n | input | 1 | Active-low PHY reset, clears negotiation results |
| phy_kind | input | 2 | 0 serial-gigabit, 1 fibre, 2 reserved, 3 coax |
| tick_short | input | 1 | Short link-timer pulse, one clock wide |
| tick_long | input | 1 | Long link-timer pulse, one clock wide |
| speed_force | input | 2 | Nonzero value overrides the decoded speed |
| neg_off | input | 1 | Disables negotiation and forces the PHY up |
| rx_is_k | input | 1 | Received byte is a control character |
| rx_byte | input | 8 | Received PCS byte |
| partner_link | output | 1 | Partner's advertised link state |
| partner_fdx | output | 1 | Partner's advertised full duplex |
| speed_out | output | 2 | Effective speed code |
| phy_up | output | 1 | PHY considered up |
| tx_cfg_word | output | 16 | Configuration word to transmit |
| an_phase | output | 3 | Sequencer phase code |

## Verification
The embedded assertions check the control relations on every cycle. They cover the forced `phy_up` under `neg_off`, the clearing under PHY reset, the drop of `phy_up` after a primary configuration set, partner fields that hold steady without one, and phases that wait while their timer pulse or configuration word is missing. Only the directed scenarios can show the counting behaviour: three matching words, a restart of the count on a mismatch or a missing acknowledge bit, two timer pulses per timed phase, and the choice of timer by PHY kind. The scenarios also cover the field extraction from real byte sequences and the effect of the speed override.

// File: rtl/sgl_autoneg_pkg.sv
// Shared codes and types for the link auto-negotiation controller.
// Assumes 8-bit PCS symbols with a separate control flag.
package sgl_autoneg_pkg;
    localparam int SYM_W     = 8;
    localparam int HIST_LEN  = 4;
    localparam int WORD_W    = 2 * SYM_W;

    localparam logic [SYM_W-1:0] SYM_COMMA  = 8'hBC;
    localparam logic [SYM_W-1:0] SYM_CFG_A  = 8'hB5;
    localparam logic [SYM_W-1:0] SYM_CFG_B  = 8'h42;
    localparam logic [SYM_W-1:0] SYM_IDLE2  = 8'h50;
    localparam logic [SYM_W-1:0] TXW_LO     = 8'h21;
    localparam logic [SYM_W-1:0] TXW_HI_ACK = 8'h40;
    localparam logic [SYM_W-1:0] TXW_HI_NAK = 8'h00;
    localparam int               ACK_BIT    = 14;

    localparam logic [1:0] SPD_RSVD  = 2'b11;
    localparam logic [1:0] KIND_FIBRE = 2'd1;

    typedef struct packed {
        logic             k;
        logic [SYM_W-1:0] d;
    } sym_t;

    typedef enum logic [2:0] {
        PH_OFF      = 3'd0,
        PH_ENABLE   = 3'd1,
        PH_RESTART  = 3'd2,
        PH_ABILITY  = 3'd3,
        PH_ACKWAIT  = 3'd4,
        PH_ACKDONE  = 3'd5,
        PH_IDLEWAIT = 3'd6,
        PH_LINKOK   = 3'd7
    } an_phase_t;
endpackage

// File: rtl/sgl_rx_decode.sv
// Keeps the last HIST_LEN received symbols and flags complete ordered
// sets: primary/secondary configuration sets and IDLE2 pairs.
// Assumes one symbol per clock; index 0 is the newest symbol.
module sgl_rx_decode
    import sgl_autoneg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_is_k,
    input  logic [SYM_W-1:0]  rx_byte,
    output logic              cfg_any,
    output logic              cfg_main,
    output logic              idle2_seen,
    output logic [WORD_W-1:0] cfg_word
);
    localparam int OLD = HIST_LEN - 1;

    sym_t hist [HIST_LEN];

    // newest stage captures the incoming symbol
    always_ff @(posedge clk) begin
        if (!rst_n) hist[0] <= '0;
        else        hist[0] <= sym_t'{k: rx_is_k, d: rx_byte};
    end

    // older stages shift down the history
    for (genvar s = 1; s < HIST_LEN; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) hist[s] <= '0;
            else        hist[s] <= hist[s-1];
        end
    end

    logic comma_old, marker_a, marker_b, payload_ok;

    // classify the history window
    always_comb begin
        comma_old  = hist[OLD].k && (hist[OLD].d == SYM_COMMA);
        marker_a   = !hist[OLD-1].k && (hist[OLD-1].d == SYM_CFG_A);
        marker_b   = !hist[OLD-1].k && (hist[OLD-1].d == SYM_CFG_B);
        payload_ok = !hist[1].k && !hist[0].k;
        cfg_main   = comma_old && marker_a && payload_ok;
        cfg_any    = comma_old && (marker_a || marker_b) && payload_ok;
        idle2_seen = hist[1].k && (hist[1].d == SYM_COMMA) &&
                     !hist[0].k && (hist[0].d == SYM_IDLE2);
        cfg_word   = {hist[0].d, hist[1].d};
    end
endmodule

// File: rtl/sgl_partner_regs.sv
// Holds the partner's advertised link, duplex and speed, and the
// phy_up flag. Priority: PHY reset, negotiation off, config, IDLE2.
module sgl_partner_regs
    import sgl_autoneg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phy_rst_n,
    input  logic       neg_off,
    input  logic       cfg_main,
    input  logic       idle2_seen,
    input  logic       ad_link,
    input  logic       ad_fdx,
    input  logic [1:0] ad_spd,
    output logic       partner_link,
    output logic       partner_fdx,
    output logic [1:0] partner_spd,
    output logic       phy_up
);
    // update partner fields and PHY state
    always_ff @(posedge clk) begin
        if (!rst_n || !phy_rst_n) begin
            partner_link <= 1'b0;
            partner_fdx  <= 1'b0;
            partner_spd  <= SPD_RSVD;
            phy_up       <= 1'b0;
        end else if (neg_off) begin
            phy_up <= 1'b1;
        end else if (cfg_main) begin
            partner_link <= ad_link;
            partner_fdx  <= ad_fdx;
            partner_spd  <= ad_spd;
            phy_up       <= 1'b0;
        end else if (idle2_seen) begin
            phy_up <= 1'b1;
        end
    end

    a_r5_off_forces_up: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rst_n && neg_off) |=> phy_up);
    a_r6_phy_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_rst_n |=> (!partner_link && !partner_fdx && partner_spd == SPD_RSVD && !phy_up));
    a_r4_cfg_drops_up: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rst_n && !neg_off && cfg_main) |=> !phy_up);
    a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rst_n && !cfg_main) |=> ($stable(partner_link) && $stable(partner_fdx) && $stable(partner_spd)));
endmodule

// File: rtl/sgl_neg_seq.sv
// Negotiation sequencer: matches consecutive configuration words,
// waits on link-timer pulses and produces the transmit config word.
// Assumes tick is a one-clock pulse and cfg_any lasts one clock.
module sgl_neg_seq
    import sgl_autoneg_pkg::*;
#(
    parameter int MATCH_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_rst_n,
    input  logic              neg_off,
    input  logic              tick,
    input  logic              cfg_any,
    input  logic [WORD_W-1:0] cfg_word,
    output an_phase_t         phase,
    output logic [WORD_W-1:0] tx_cfg_word
);
    localparam int              CNT_W    = $clog2(MATCH_N + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MATCH_N - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] last_word;
    logic              armed;
    logic              hold_off;

    // any of the three conditions parks the sequencer
    always_comb hold_off = !rst_n || !phy_rst_n || neg_off;

    // phase transitions, match counting and timer arming
    always_ff @(posedge clk) begin
        if (hold_off) begin
            phase     <= PH_OFF;
            cnt       <= '0;
            last_word <= '0;
            armed     <= 1'b0;
        end else begin
            case (phase)
                PH_OFF:     phase <= PH_ENABLE;
                PH_ENABLE:  phase <= PH_RESTART;
                PH_RESTART: if (tick) begin
                    phase <= PH_ABILITY;
                    cnt   <= '0;
                end
                PH_ABILITY: if (cfg_any) begin
                    last_word <= cfg_word;
                    if (cnt != '0 && cfg_word == last_word) begin
                        if (cnt == CNT_LAST) begin
                            phase <= PH_ACKWAIT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CNT_ONE;
                        end
                    end else begin
                        cnt <= CNT_ONE;
                    end
                end
                PH_ACKWAIT: if (cfg_any) begin
                    if (cfg_word[ACK_BIT]) begin
                        if (cnt == CNT_LAST) begin
                            phase <= PH_ACKDONE;
                            cnt   <= '0;
                            armed <= 1'b0;
                        end else begin
                            cnt <= cnt + CNT_ONE;
                        end
                    end else begin
                        cnt <= '0;
                    end
                end
                PH_ACKDONE, PH_IDLEWAIT: if (tick) begin
                    if (armed) begin
                        phase <= (phase == PH_ACKDONE) ? PH_IDLEWAIT : PH_LINKOK;
                        armed <= 1'b0;
                    end else begin
                        armed <= 1'b1;
                    end
                end
                PH_LINKOK: if (cfg_any) begin
                    phase     <= PH_ABILITY;
                    cnt       <= CNT_ONE;
                    last_word <= cfg_word;
                end
                default: phase <= PH_OFF;
            endcase
        end
    end

    // transmit word: acknowledge bit once past ability matching
    always_comb tx_cfg_word = {(phase >= PH_ACKWAIT) ? TXW_HI_ACK : TXW_HI_NAK, TXW_LO};

    a_r9_restart_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESTART && !tick && phy_rst_n && !neg_off) |=> phase == PH_RESTART);
    a_r10_ability_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ABILITY && !cfg_any && phy_rst_n && !neg_off) |=> phase == PH_ABILITY);
    a_r12_timed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_ACKDONE || phase == PH_IDLEWAIT) && !tick && phy_rst_n && !neg_off) |=> $stable(phase));
    a_r13_linkok_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LINKOK && cfg_any && phy_rst_n && !neg_off) |=> phase == PH_ABILITY);
endmodule

// File: rtl/sgl_autoneg.sv
// Top of the link auto-negotiation controller: symbol history decode,
// partner field capture, sequencer, timer selection and speed override.
// Assumes one PCS symbol per clock and one-clock-wide timer pulses.
module sgl_autoneg
    import sgl_autoneg_pkg::*;
#(
    parameter int MATCH_N = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phy_rst_n,
    input  logic [1:0]  phy_kind,
    input  logic        tick_short,
    input  logic        tick_long,
    input  logic [1:0]  speed_force,
    input  logic        neg_off,
    input  logic        rx_is_k,
    input  logic [7:0]  rx_byte,
    output logic        partner_link,
    output logic        partner_fdx,
    output logic [1:0]  speed_out,
    output logic        phy_up,
    output logic [15:0] tx_cfg_word,
    output logic [2:0]  an_phase
);
    logic              cfg_any, cfg_main, idle2_seen, tick;
    logic [WORD_W-1:0] cfg_word;
    logic [1:0]        partner_spd;
    an_phase_t         phase;

    sgl_rx_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_is_k    (rx_is_k),
        .rx_byte    (rx_byte),
        .cfg_any    (cfg_any),
        .cfg_main   (cfg_main),
        .idle2_seen (idle2_seen),
        .cfg_word   (cfg_word)
    );

    sgl_partner_regs u_partner (
        .clk          (clk),
        .rst_n        (rst_n),
        .phy_rst_n    (phy_rst_n),
        .neg_off      (neg_off),
        .cfg_main     (cfg_main),
        .idle2_seen   (idle2_seen),
        .ad_link      (cfg_word[15]),
        .ad_fdx       (cfg_word[12]),
        .ad_spd       (cfg_word[11:10]),
        .partner_link (partner_link),
        .partner_fdx  (partner_fdx),
        .partner_spd  (partner_spd),
        .phy_up       (phy_up)
    );

    // link timer source follows the PHY kind
    always_comb tick = (phy_kind == KIND_FIBRE) ? tick_long : tick_short;

    sgl_neg_seq #(.MATCH_N(MATCH_N)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .phy_rst_n   (phy_rst_n),
        .neg_off     (neg_off),
        .tick        (tick),
        .cfg_any     (cfg_any),
        .cfg_word    (cfg_word),
        .phase       (phase),
        .tx_cfg_word (tx_cfg_word)
    );

    // speed override and phase export
    always_comb begin
        speed_out = (speed_force != 2'b00) ? speed_force : partner_spd;
        an_phase  = phase;
    end
endmodule

// File: tb/sgl_autoneg_tb.sv
module sgl_autoneg_tb;
    logic        clk = 1'b0;
    logic        rst_n, phy_rst_n, tick_short, tick_long, neg_off, rx_is_k;
    logic [1:0]  phy_kind, speed_force;
    logic [7:0]  rx_byte;
    logic        partner_link, partner_fdx, phy_up;
    logic [1:0]  speed_out;
    logic [15:0] tx_cfg_word;
    logic [2:0]  an_phase;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sgl_autoneg u_dut (
        .clk(clk), .rst_n(rst_n), .phy_rst_n(phy_rst_n), .phy_kind(phy_kind),
        .tick_short(tick_short), .tick_long(tick_long), .speed_force(speed_force),
        .neg_off(neg_off), .rx_is_k(rx_is_k), .rx_byte(rx_byte),
        .partner_link(partner_link), .partner_fdx(partner_fdx), .speed_out(speed_out),
        .phy_up(phy_up), .tx_cfg_word(tx_cfg_word), .an_phase(an_phase)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic k, input logic [7:0] b);
        @(negedge clk);
        rx_is_k = k;
        rx_byte = b;
    endtask

    // configuration set, then two fillers so the result is visible
    task automatic send_cfg(input logic primary, input logic [7:0] hi, input logic [7:0] lo);
        put(1'b1, 8'hBC);
        put(1'b0, primary ? 8'hB5 : 8'h42);
        put(1'b0, lo);
        put(1'b0, hi);
        put(1'b0, 8'h00);
        put(1'b0, 8'h00);
    endtask

    task automatic pulse(input logic use_long);
        @(negedge clk);
        if (use_long) tick_long = 1'b1; else tick_short = 1'b1;
        @(negedge clk);
        tick_long  = 1'b0;
        tick_short = 1'b0;
    endtask

    task automatic t_reset_and_timer();
        rst_n = 1'b0; phy_rst_n = 1'b1; neg_off = 1'b0; phy_kind = 2'd1;
        speed_force = 2'b00; tick_short = 1'b0; tick_long = 1'b0;
        rx_is_k = 1'b0; rx_byte = 8'h00;
        repeat (3) @(negedge clk);
        chk({13'd0, an_phase}, 16'd0, "R1 phase");
        chk({15'd0, phy_up}, 16'd0, "R1 phy_up");
        chk({14'd0, partner_link, partner_fdx}, 16'd0, "R1 fields");
        chk({14'd0, speed_out}, 16'h3, "R1 speed");
        chk(tx_cfg_word, 16'h0021, "R1 tx word");
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk({13'd0, an_phase}, 16'd2, "R9 reaches restart");
        pulse(1'b0);
        chk({13'd0, an_phase}, 16'd2, "R14 short pulse ignored for kind 1");
        pulse(1'b1);
        chk({13'd0, an_phase}, 16'd3, "R14 R9 long pulse leaves restart");
        phy_kind = 2'd0;
    endtask

    task automatic t_ability();
        chk(tx_cfg_word, 16'h0021, "R8 no ack in phase 3");
        send_cfg(1'b1, 8'h98, 8'h01);
        send_cfg(1'b1, 8'h98, 8'h01);
        send_cfg(1'b1, 8'h94, 8'h01);
        send_cfg(1'b1, 8'h94, 8'h01);
        chk({13'd0, an_phase}, 16'd3, "R10 mismatch restarts count");
        send_cfg(1'b1, 8'h94, 8'h01);
        chk({13'd0, an_phase}, 16'd4, "R10 three equal words");
        chk({13'd0, partner_link, partner_fdx, 1'b0}, 16'h6, "R2 link and duplex");
        chk({14'd0, speed_out}, 16'h1, "R2 speed bits");
        chk({15'd0, phy_up}, 16'd0, "R4 config clears phy_up");
        chk(tx_cfg_word, 16'h4021, "R8 ack in phase 4");
    endtask

    task automatic t_ack();
        send_cfg(1'b1, 8'hD8, 8'h01);
        send_cfg(1'b1, 8'hD8, 8'h01);
        send_cfg(1'b1, 8'h98, 8'h01);
        send_cfg(1'b1, 8'hD8, 8'h01);
        send_cfg(1'b1, 8'hD8, 8'h01);
        chk({13'd0, an_phase}, 16'd4, "R11 missing ack resets count");
        send_cfg(1'b1, 8'hD8, 8'h01);
        chk({13'd0, an_phase}, 16'd5, "R11 three ack words");
        chk({14'd0, speed_out}, 16'h2, "R2 speed from ack word");
    endtask

    task automatic t_timed();
        pulse(1'b0);
        chk({13'd0, an_phase}, 16'd5, "R12 first pulse holds phase 5");
        pulse(1'b0);
        chk({13'd0, an_phase}, 16'd6, "R12 second pulse leaves phase 5");
        pulse(1'b0);
        chk({13'd0, an_phase}, 16'd6, "R12 first pulse holds phase 6");
        pulse(1'b0);
        chk({13'd0, an_phase}, 16'd7, "R12 second pulse reaches link OK");
    endtask

    task automatic t_idle_and_reopen();
        put(1'b1, 8'hBC); put(1'b0, 8'h50); put(1'b0, 8'h00); put(1'b0, 8'h00);
        chk({15'd0, phy_up}, 16'd1, "R4 IDLE2 sets phy_up");
        send_cfg(1'b1, 8'hD8, 8'h01);
        chk({13'd0, an_phase}, 16'd3, "R13 config in link OK reopens");
        chk({15'd0, phy_up}, 16'd0, "R4 config clears phy_up again");
    endtask

    task automatic t_secondary();
        send_cfg(1'b0, 8'h00, 8'h00);
        chk({14'd0, partner_link, partner_fdx}, 16'h3, "R3 secondary set leaves fields");
        chk({14'd0, speed_out}, 16'h2, "R3 secondary set leaves speed");
    endtask

    task automatic t_force();
        @(negedge clk); speed_force = 2'b01;
        @(negedge clk);
        chk({14'd0, speed_out}, 16'h1, "R7 forced speed");
        speed_force = 2'b00;
        @(negedge clk);
        chk({14'd0, speed_out}, 16'h2, "R7 decoded speed passes");
    endtask

    task automatic t_off();
        @(negedge clk); neg_off = 1'b1;
        @(negedge clk);
        chk({15'd0, phy_up}, 16'd1, "R5 phy_up forced");
        chk({13'd0, an_phase}, 16'd0, "R5 phase held off");
        send_cfg(1'b1, 8'h00, 8'h00);
        chk({14'd0, partner_link, partner_fdx}, 16'h3, "R5 config ignored");
        chk({13'd0, an_phase}, 16'd0, "R5 phase still off");
    endtask

    task automatic t_phy_reset();
        @(negedge clk); phy_rst_n = 1'b0;
        @(negedge clk);
        chk({14'd0, partner_link, partner_fdx}, 16'h0, "R6 fields cleared");
        chk({14'd0, speed_out}, 16'h3, "R6 speed reserved");
        chk({15'd0, phy_up}, 16'd0, "R6 phy_up cleared over neg_off");
        chk({13'd0, an_phase}, 16'd0, "R6 phase off");
        phy_rst_n = 1'b1; neg_off = 1'b0;
        @(negedge clk); @(negedge clk);
        chk({13'd0, an_phase}, 16'd2, "R9 restart after release");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset_and_timer();
        t_ability();
        t_ack();
        t_timed();
        t_idle_and_reopen();
        t_secondary();
        t_force();
        t_off();
        t_phy_reset();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule